// File: doc/BRIEF.md
# PWM Compare Output Channel

This block is one compare channel of a timer. A shared timebase supplies the counter value and the counting direction. The channel compares that count against its own duty value and produces a reference PWM waveform and a sticky compare flag. Software programs the channel through four settings. The first is a 3-bit output mode. The second is a 2-bit alignment setting. The third is a preload-enable bit. The last is a write port for the duty value. A single-cycle clear input resets the flag. Output polarity, complementary outputs, dead-time and interrupt routing are handled elsewhere.

The duty value is either applied at once or held in a preload buffer until the timebase signals an update event. A small state machine tracks the reference output. It has three states:

- `ST_IDLE`: a non-PWM mode is selected, and the output is low.
- `ST_ACTIVE`: the output is high.
- `ST_INACTIVE`: the output is low.

Each clock, the next state comes from the mode and from the test "count below the active duty value". The transitions are:

- Any state moves to `ST_IDLE` when the mode is not PWM.
- Any state moves to `ST_ACTIVE` when the PWM condition is true.
- Any state moves to `ST_INACTIVE` when the PWM condition is false.

The falling transition `ST_ACTIVE` → `ST_INACTIVE` is the compare event in edge-aligned operation.

Top module: `pwm_cmp_channel`

## Requirements
- R1: After reset, `oc_ref` is 0, `cmp_flag` is 0 and the active duty value is 0.
- R2: With `oc_mode` = 3'b110 (PWM mode 1), `oc_ref` after a clock edge is 1 when the `cnt` sampled at that edge is below the active duty value, and 0 otherwise.
- R3: In PWM mode 1, a duty value above the highest count keeps `oc_ref` at 1 for every count. A duty value of 0 keeps `oc_ref` at 0 for every count.
- R4: With `oc_mode` = 3'b111 (PWM mode 2), `oc_ref` is the inverse of the mode 1 result, including the two pinned cases.
- R5: Any `oc_mode` other than 3'b110 or 3'b111 drives `oc_ref` to 0, and the compare flag is never set in that mode.
- R6: With `preload_en` = 1, a write lands in the preload buffer only. It becomes the active duty value at the clock edge where `update_evt` is 1.
- R7: With `preload_en` = 0, a write at edge k becomes active at edge k, so it governs `oc_ref` from the next cycle on.
- R8: With `align_mode` = 2'b00 (edge-aligned), `cmp_flag` is set at the edge where `oc_ref` goes from 1 to 0 in a PWM mode.
- R9: In center-aligned operation, `cmp_flag` is set when `cnt` equals the active duty value in a PWM mode and the direction matches. `align_mode` = 2'b01 sets it only while counting down (`cnt_dn` = 1). 2'b10 sets it only while counting up. 2'b11 sets it in both directions.
- R10: `cmp_flag` stays at 1 until a `flag_clr` pulse. When a clear and a set arrive in the same cycle, the flag is left at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt | input | CNT_W | Timebase count |
| cnt_dn | input | 1 | Timebase direction, 1 = counting down |
| update_evt | input | 1 | Update event pulse from the timebase |
| cmp_wr | input | 1 | Duty value write strobe |
| cmp_wdata | input | CNT_W | Duty value to write |
| preload_en | input | 1 | 1 = buffer writes until an update event |
| oc_mode | input | 3 | Output mode (110 PWM1, 111 PWM2, other = output low) |
| align_mode | input | 2 | 00 edge, 01 flag on down, 10 flag on up, 11 flag on both |
| flag_clr | input | 1 | Flag clear pulse |
| oc_ref | output | 1 | Reference PWM output |
| cmp_flag | output | 1 | Sticky compare flag |

## Verification
Both outputs are registered once from the inputs sampled at an edge. A count, mode or direction presented before edge k is therefore seen on `oc_ref` and `cmp_flag` just after edge k. A duty write without preload reaches `oc_ref` one edge later, and a preloaded write one edge after the update pulse. The bench drives every input 1 ns after a rising edge. It steps exactly one edge per tick and samples 1 ns after that edge. Its expected values come from a per-tick model of the duty register, the previous output and the flag, advanced in the same order.

// File: rtl/pwm_ch_pkg.sv
package pwm_ch_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'b00,
        ST_ACTIVE   = 2'b01,
        ST_INACTIVE = 2'b10
    } ref_state_t;

    localparam logic [2:0] MODE_PWM1 = 3'b110;
    localparam logic [2:0] MODE_PWM2 = 3'b111;

    localparam logic [1:0] ALIGN_EDGE = 2'b00;
    localparam logic [1:0] ALIGN_DN   = 2'b01;
    localparam logic [1:0] ALIGN_UP   = 2'b10;
    localparam logic [1:0] ALIGN_BOTH = 2'b11;
endpackage

// File: rtl/pwm_duty_reg.sv
module pwm_duty_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             preload_en,
    input  logic             update_evt,
    output logic [CNT_W-1:0] duty_act
);
    logic [CNT_W-1:0] duty_buf;

    // buffer always captures writes; active copy follows by mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_buf <= '0;
            duty_act <= '0;
        end else begin
            if (cmp_wr)
                duty_buf <= cmp_wdata;
            if (cmp_wr && !preload_en)
                duty_act <= cmp_wdata;
            else if (update_evt && preload_en)
                duty_act <= duty_buf;
        end
    end
endmodule

// File: rtl/pwm_ref_fsm.sv
module pwm_ref_fsm
    import pwm_ch_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] duty_act,
    input  logic [2:0]       oc_mode,
    output logic             oc_ref,
    output logic             fall_evt,
    output logic             pwm_on
);
    ref_state_t state_q, state_d;
    logic       below;

    assign below  = (cnt < duty_act);
    assign pwm_on = (oc_mode == MODE_PWM1) || (oc_mode == MODE_PWM2);

    always_comb begin
        unique case (oc_mode)
            MODE_PWM1: state_d = below ? ST_ACTIVE : ST_INACTIVE;
            MODE_PWM2: state_d = below ? ST_INACTIVE : ST_ACTIVE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        oc_ref   = (state_q == ST_ACTIVE);
        fall_evt = (state_q == ST_ACTIVE) && (state_d == ST_INACTIVE);
    end
endmodule

// File: rtl/pwm_flag_unit.sv
module pwm_flag_unit
    import pwm_ch_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_dn,
    input  logic [CNT_W-1:0] duty_act,
    input  logic [1:0]       align_mode,
    input  logic             pwm_on,
    input  logic             fall_evt,
    input  logic             flag_clr,
    output logic             cmp_flag
);
    logic hit, set_now;

    assign hit = pwm_on && (cnt == duty_act);

    always_comb begin
        unique case (align_mode)
            ALIGN_EDGE: set_now = fall_evt;
            ALIGN_DN:   set_now = hit && cnt_dn;
            ALIGN_UP:   set_now = hit && !cnt_dn;
            ALIGN_BOTH: set_now = hit;
        endcase
    end

    // set wins over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cmp_flag <= 1'b0;
        else if (set_now)  cmp_flag <= 1'b1;
        else if (flag_clr) cmp_flag <= 1'b0;
    end
endmodule

// File: rtl/pwm_cmp_channel.sv
module pwm_cmp_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_dn,
    input  logic             update_evt,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             preload_en,
    input  logic [2:0]       oc_mode,
    input  logic [1:0]       align_mode,
    input  logic             flag_clr,
    output logic             oc_ref,
    output logic             cmp_flag
);
    logic [CNT_W-1:0] duty_act;
    logic             fall_evt;
    logic             pwm_on;

    pwm_duty_reg #(.CNT_W(CNT_W)) duty_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_wr     (cmp_wr),
        .cmp_wdata  (cmp_wdata),
        .preload_en (preload_en),
        .update_evt (update_evt),
        .duty_act   (duty_act)
    );

    pwm_ref_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt),
        .duty_act (duty_act),
        .oc_mode  (oc_mode),
        .oc_ref   (oc_ref),
        .fall_evt (fall_evt),
        .pwm_on   (pwm_on)
    );

    pwm_flag_unit #(.CNT_W(CNT_W)) flag_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt        (cnt),
        .cnt_dn     (cnt_dn),
        .duty_act   (duty_act),
        .align_mode (align_mode),
        .pwm_on     (pwm_on),
        .fall_evt   (fall_evt),
        .flag_clr   (flag_clr),
        .cmp_flag   (cmp_flag)
    );
endmodule

// File: rtl/pwm_cmp_channel_chk.sv
module pwm_cmp_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_dn,
    input logic             update_evt,
    input logic             cmp_wr,
    input logic [CNT_W-1:0] cmp_wdata,
    input logic             preload_en,
    input logic [2:0]       oc_mode,
    input logic [1:0]       align_mode,
    input logic             flag_clr,
    input logic             oc_ref,
    input logic             cmp_flag
);
    // R5
    nonpwm_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_mode[2:1] != 2'b11) |=> !oc_ref);

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && !flag_clr) |=> cmp_flag);

    // R8
    edge_fall_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(oc_ref) && $past(align_mode) == 2'b00 && $past(oc_mode[2:1]) == 2'b11)
        |-> cmp_flag);

    // R9
    down_only_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cmp_flag) && $past(align_mode) == 2'b01) |-> $past(cnt_dn));

    // R3
    zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!preload_en && cmp_wr && cmp_wdata == '0)
        ##1 (oc_mode == 3'b110 && !cmp_wr && !update_evt) |=> !oc_ref);
endmodule

bind pwm_cmp_channel pwm_cmp_channel_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/pwm_cmp_channel_tb_top.sv
module pwm_cmp_channel_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt = '0;
    logic         cnt_dn = 1'b0;
    logic         update_evt = 1'b0;
    logic         cmp_wr = 1'b0;
    logic [W-1:0] cmp_wdata = '0;
    logic         preload_en = 1'b0;
    logic [2:0]   oc_mode = 3'b000;
    logic [1:0]   align_mode = 2'b00;
    logic         flag_clr = 1'b0;
    logic         oc_ref, cmp_flag;

    int n_chk = 0;
    int n_bad = 0;

    logic [W-1:0] m_act = '0;
    logic [W-1:0] m_buf = '0;
    logic         m_ref = 1'b0;
    logic         m_flag = 1'b0;

    always #2 clk = ~clk;

    pwm_cmp_channel #(.CNT_W(W)) dut_i (.*);

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic tick(input string req);
        logic pwm, below, e_ref, hit, setv;
        pwm   = (oc_mode[2:1] == 2'b11);
        below = (cnt < m_act);
        e_ref = (oc_mode == 3'b110) ? below : (oc_mode == 3'b111) ? !below : 1'b0;
        hit   = pwm && (cnt == m_act);
        case (align_mode)
            2'b00:   setv = pwm && m_ref && !e_ref;
            2'b01:   setv = hit && cnt_dn;
            2'b10:   setv = hit && !cnt_dn;
            default: setv = hit;
        endcase
        if (setv) m_flag = 1'b1;
        else if (flag_clr) m_flag = 1'b0;
        m_ref = e_ref;
        if (cmp_wr && !preload_en) m_act = cmp_wdata;
        else if (update_evt && preload_en) m_act = m_buf;
        if (cmp_wr) m_buf = cmp_wdata;
        @(posedge clk);
        #1;
        check(req, "oc_ref", oc_ref, m_ref);
        check(req, "cmp_flag", cmp_flag, m_flag);
        cmp_wr = 1'b0;
        update_evt = 1'b0;
        flag_clr = 1'b0;
    endtask

    task automatic sweep(input int lo, input int hi, input logic dn, input string req);
        if (lo <= hi) begin
            for (int i = lo; i <= hi; i++) begin cnt = W'(i); cnt_dn = dn; tick(req); end
        end else begin
            for (int i = lo; i >= hi; i--) begin cnt = W'(i); cnt_dn = dn; tick(req); end
        end
    endtask

    task automatic write_duty(input int v, input string req);
        cmp_wr = 1'b1;
        cmp_wdata = W'(v);
        tick(req);
    endtask

    task automatic t_reset;
        check("R1", "oc_ref", oc_ref, 1'b0);
        check("R1", "cmp_flag", cmp_flag, 1'b0);
        rst_n = 1'b1;
        oc_mode = 3'b110;
        cnt = '0;
        tick("R1"); // duty 0 after reset: count 0 not below -> low
    endtask

    task automatic t_mode1;
        write_duty(5, "R7");
        sweep(0, 8, 1'b0, "R2");
    endtask

    task automatic t_pinned;
        write_duty(12, "R3");
        sweep(0, 8, 1'b0, "R3");
        write_duty(0, "R3");
        sweep(0, 8, 1'b0, "R3");
    endtask

    task automatic t_mode2;
        oc_mode = 3'b111;
        write_duty(5, "R4");
        sweep(0, 8, 1'b0, "R4");
        write_duty(0, "R4");
        sweep(0, 8, 1'b0, "R4");
        write_duty(12, "R4");
        sweep(0, 8, 1'b0, "R4");
    endtask

    task automatic t_invalid;
        oc_mode = 3'b110;
        write_duty(5, "R5");
        flag_clr = 1'b1;
        tick("R5");
        oc_mode = 3'b000;
        sweep(0, 8, 1'b0, "R5");
        oc_mode = 3'b101;
        align_mode = 2'b11;
        sweep(8, 0, 1'b1, "R5");
        align_mode = 2'b00;
    endtask

    task automatic t_preload;
        oc_mode = 3'b110;
        preload_en = 1'b1;
        write_duty(2, "R6");
        sweep(0, 8, 1'b0, "R6");   // still duty 5
        update_evt = 1'b1;
        tick("R6");
        sweep(0, 8, 1'b0, "R6");   // now duty 2
        preload_en = 1'b0;
    endtask

    task automatic t_immediate;
        cnt = W'(3);
        write_duty(6, "R7");
        tick("R7");                // 3 < 6 -> high
        write_duty(3, "R7");       // still high this edge
        tick("R7");                // 3 < 3 false -> low
    endtask

    task automatic t_edge_flag;
        write_duty(4, "R8");
        flag_clr = 1'b1;
        cnt = '0;
        tick("R8");
        sweep(0, 8, 1'b0, "R8");
        sweep(0, 2, 1'b0, "R8");
    endtask

    task automatic t_center;
        for (int a = 1; a <= 3; a++) begin
            align_mode = 2'(a);
            flag_clr = 1'b1;
            cnt = '0;
            tick("R9");
            sweep(0, 8, 1'b0, "R9");
            flag_clr = 1'b1;
            cnt = 8'd8;
            cnt_dn = 1'b1;
            tick("R9");
            sweep(8, 0, 1'b1, "R9");
        end
    endtask

    task automatic t_clear;
        align_mode = 2'b11;
        cnt = W'(4);
        tick("R10");               // match sets flag
        flag_clr = 1'b1;
        tick("R10");               // set and clear together: stays 1
        cnt = W'(7);
        tick("R10");               // no clear: stays 1
        flag_clr = 1'b1;
        tick("R10");               // clear alone: 0
        check("R10", "cleared", cmp_flag, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_mode1();
        t_pinned();
        t_mode2();
        t_invalid();
        t_preload();
        t_immediate();
        t_edge_flag();
        t_center();
        t_clear();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule